// File: doc/BRIEF.md
# Linked List Summing Engine

This block walks a singly linked list stored in a word-addressed memory and totals the value fields of the nodes it visits. A node occupies two adjacent words: the word at the node's own address holds the link to the following node, and the word one address higher holds the node's value. A start pulse clears the running link and the running total, so every walk begins with the node at address zero. The walk repeats until a freshly fetched link is zero. The test comes after the node has been added, so the node at address zero always counts.

Internally a small controller sequences a datapath through six control points. These are a link load enable, a link source select, a total load enable, a total source select, an address select and a result load. The datapath reports one status bit back to the controller: whether the link word now on the read bus is zero. One memory read address is shared between the link and the link plus one. Reads return their word one cycle after the address is presented. The memory port has a fixed latency and no back-pressure: the memory must answer every address on time. Start and done are plain level pins with no handshake.

Top module: `list_sum_engine`

## Requirements
- R1: While reset is held and after it is released with no start, done is 0 and result is 0.
- R2: A start pulse accepted while idle or done clears the link and the total to zero. The first address presented afterwards is 1 (the value word of the node at 0), followed by address 0 (its link word).
- R3: For a list of nodes reached by following links from address 0, result equals the sum of the value words of all visited nodes. This includes the final node, whose link is zero.
- R4: The node at address 0 is always included, even when its own link is zero. That single-node walk returns the word at address 1.
- R5: The total is as wide as the data word and wraps modulo 2^DW on overflow, with no saturation.
- R6: Only the low AW bits of a link word form the next address and the zero test. Upper bits of a link word are ignored.
- R7: Each node costs exactly three cycles. Done rises 3·N clock edges after the edge that samples start, for a list of N nodes.
- R8: Done stays high and result stays stable until the next accepted start. Done falls on the edge that accepts that start.
- R9: A start pulse that arrives while a walk is in progress is ignored. The walk's result and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a walk from address 0 |
| mem_addr | output | AW | Read address to the list memory |
| mem_rdata | input | DW | Word read from memory, valid one cycle after its address |
| result | output | DW | Total of the last completed walk |
| done | output | 1 | High from the end of a walk until the next accepted start |

## Verification
A wrong link register shows up within one node. The engine either reads value words that do not belong to the list, so result is off, or misses the zero link, so done comes late or never. A corrupted total or a fault in the add path appears only as a wrong result at the next rise of done, while the latency stays correct. A sequencing fault, such as a restart mid-walk or a skipped state, moves the rise of done away from the 3·N edge mark. For that reason every walk is checked on both its total and its exact completion cycle.

// File: rtl/lsum_pkg.sv
`timescale 1ns/1ps
package lsum_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_VAL  = 3'd1,
    ST_PTR  = 3'd2,
    ST_LINK = 3'd3,
    ST_DONE = 3'd4
  } lsum_state_e;

  // control points from controller to datapath
  typedef struct packed {
    logic ld_link;   // load link register
    logic link_mem;  // 1: link from memory, 0: clear
    logic ld_acc;    // load total register
    logic acc_add;   // 1: total + memory word, 0: clear
    logic addr_inc;  // 1: address = link + 1, 0: address = link
    logic ld_res;    // copy total to result
  } lsum_ctl_t;
endpackage

// File: rtl/lsum_dpath.sv
`timescale 1ns/1ps
module lsum_dpath
  import lsum_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lsum_ctl_t     ctl,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] rd_addr,
  output logic          link_zero,
  output logic [DW-1:0] total
);
  logic [AW-1:0] link_q;
  logic [AW-1:0] link_inc;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] res_q;
  logic [AW-1:0] word_link;

  assign word_link = rd_word[AW-1:0];
  assign link_inc  = link_q + AW'(1);
  assign rd_addr   = ctl.addr_inc ? link_inc : link_q;
  assign link_zero = (word_link == '0);
  assign total     = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q <= '0;
      acc_q  <= '0;
      res_q  <= '0;
    end else begin
      if (ctl.ld_link) link_q <= ctl.link_mem ? word_link : '0;
      if (ctl.ld_acc)  acc_q  <= ctl.acc_add ? (acc_q + rd_word) : '0;
      if (ctl.ld_res)  res_q  <= acc_q;
    end
  end
endmodule

// File: rtl/lsum_ctrl.sv
`timescale 1ns/1ps
module lsum_ctrl
  import lsum_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        link_zero,
  output lsum_ctl_t   ctl,
  output lsum_state_e state,
  output logic        done
);
  lsum_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    ctl  = '0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          ctl.ld_link = 1'b1;
          ctl.ld_acc  = 1'b1;
          st_d        = ST_VAL;
        end
      end
      ST_VAL: begin
        ctl.addr_inc = 1'b1;
        st_d         = ST_PTR;
      end
      ST_PTR: begin
        ctl.ld_acc  = 1'b1;
        ctl.acc_add = 1'b1;
        st_d        = ST_LINK;
      end
      ST_LINK: begin
        ctl.ld_link  = 1'b1;
        ctl.link_mem = 1'b1;
        if (link_zero) begin
          ctl.ld_res = 1'b1;
          st_d       = ST_DONE;
        end else begin
          st_d = ST_VAL;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
  assign done  = (st_q == ST_DONE);
endmodule

// File: rtl/list_sum_engine.sv
`timescale 1ns/1ps
module list_sum_engine
  import lsum_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] result,
  output logic          done
);
  lsum_ctl_t   ctl;
  lsum_state_e fsm_state;
  logic        link_zero;

  lsum_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .link_zero (link_zero),
    .ctl       (ctl),
    .state     (fsm_state),
    .done      (done)
  );

  lsum_dpath #(.AW(AW), .DW(DW)) i_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .rd_word   (mem_rdata),
    .rd_addr   (mem_addr),
    .link_zero (link_zero),
    .total     (result)
  );
endmodule

// File: rtl/lsum_checker.sv
`timescale 1ns/1ps
module lsum_checker
  import lsum_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] result,
  input logic          done,
  input lsum_state_e   fsm_state
);
  logic idle_or_done;
  assign idle_or_done = (fsm_state == ST_IDLE) || (fsm_state == ST_DONE);

  assert_start_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_or_done && start) |=> (mem_addr == AW'(1)) && !done);

  assert_pair_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_VAL) |=> ((mem_addr + AW'(1)) == $past(mem_addr)));

  assert_end_on_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(fsm_state) == ST_LINK) && ($past(mem_rdata[AW-1:0]) == '0));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(result)));

  assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_VAL && start) |=> (fsm_state == ST_PTR));
endmodule

bind list_sum_engine lsum_checker #(.AW(AW), .DW(DW)) i_lsum_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mem_addr  (mem_addr),
  .mem_rdata (mem_rdata),
  .result    (result),
  .done      (done),
  .fsm_state (fsm_state)
);

// File: tb/test_list_sum_engine.sv
`timescale 1ns/1ps
module test_list_sum_engine;
  localparam int AW = 8;
  localparam int DW = 16;

  typedef struct {
    logic [DW-1:0] sum;
    int            due;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] result;
  logic          done;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  exp_t sb[$];
  logic prev_done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rdata <= mem[mem_addr];
  end

  list_sum_engine #(.AW(AW), .DW(DW)) i_list_sum_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .result(result), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares each completed walk against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done && !prev_done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result == e.sum, {e.tag, " result"}, int'(result), int'(e.sum));
        check(cyc == e.due, "R7 latency", cyc, e.due);
      end
    end
    prev_done <= done;
  end

  // driver: builds a list, pushes the expected total, starts the walk
  task automatic run_walk(input int addrs[$], input logic [DW-1:0] vals[$],
                          input logic [DW-1:0] hi_junk, input bit poke,
                          input string tag);
    logic [DW-1:0] s;
    exp_t e;
    int n;
    n = addrs.size();
    s = '0;
    for (int i = 0; i < n; i++) begin
      if (i < n - 1) mem[addrs[i]] = hi_junk | DW'(addrs[i+1]);
      else           mem[addrs[i]] = hi_junk;
      mem[addrs[i] + 1] = vals[i];
      s = s + vals[i];
    end
    @(negedge clk);
    e.sum = s;
    e.due = cyc + 1 + 3 * n;
    e.tag = tag;
    sb.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R8 done falls on start", int'(done), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int a[$];
    logic [DW-1:0] v[$];
    logic [DW-1:0] held;
    for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(16'h5A5A);
    repeat (3) @(negedge clk);
    check(done == 1'b0 && result == '0, "R1 reset state", int'({done, result}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && result == '0, "R1 after reset", int'({done, result}), 0);

    // single node at address 0 whose link is zero
    a = '{0}; v = '{16'h1234};
    run_walk(a, v, '0, 1'b0, "R2 R4 single node");

    // four nodes, scattered addresses
    a = '{0, 10, 40, 6}; v = '{16'h0011, 16'h0200, 16'h3000, 16'h0004};
    run_walk(a, v, '0, 1'b0, "R3 four nodes");

    // done and result hold without start
    held = result;
    repeat (6) @(negedge clk);
    check(done == 1'b1 && result == held, "R8 hold", int'(result), int'(held));

    // overflow wraps
    a = '{0, 20, 50}; v = '{16'hF000, 16'h2000, 16'h0100};
    run_walk(a, v, '0, 1'b0, "R5 wrap");

    // upper bits of link words ignored
    a = '{0, 12, 90}; v = '{16'h0001, 16'h0002, 16'h0003};
    run_walk(a, v, 16'hAB00, 1'b0, "R6 upper link bits");

    // start during a walk is ignored
    a = '{0, 30, 60, 100}; v = '{16'h0101, 16'h0202, 16'h0303, 16'h0404};
    run_walk(a, v, '0, 1'b1, "R9 mid-walk start");

    // longer list, descending addresses
    a.delete(); v.delete();
    a.push_back(0); v.push_back(16'h0007);
    for (int i = 0; i < 20; i++) begin
      a.push_back(240 - 10 * i);
      v.push_back(DW'(16'h0100 * (i + 1) + i));
    end
    run_walk(a, v, '0, 1'b0, "R3 twenty-one nodes");

    check(sb.size() == 0, "R3 all walks completed", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog R7 actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule